// File: doc/BRIEF.md
# PWM synchronization trigger controller

This block decides when a PWM timer starts a register-update synchronization. It holds one software request flag and one enable flag for each hardware trigger input. Software sets and clears these flags through a single configuration write port. Every trigger event, from software or from an enabled hardware input, produces a one-cycle start pulse for the synchronization logic downstream.

The hardware trigger inputs are asynchronous. Each one passes through a flop synchronizer and a rising-edge detector before it is used, and all of them behave in the same way. The flags also clear on their own. A set of mode bits decides when: in the cycle of the event itself, at the next loading-point pulse, when the synchronization-complete pulse arrives, or only when software writes 0. The counter, the loading-point selection and the buffered register loads live outside this block.

Top module: `pwm_sync_trig_ctrl`

## Requirements
- R1: After reset, the software request flag, all hardware enable flags, all mode bits and all start pulses are 0.
- R2: A cycle with `cfg_we_i` = 1 loads every field of `cfg_wdata_i` at once. The field layout is:
  - bit 0: software request
  - bit 1+i: enable for hardware input i
  - bit 4: hold mode
  - bit 5: enhanced mode
  - bit 6: pwmsync select
  - bit 7: reinit select
  - bit 8: counter-reset select
- R3: A write with bit 0 = 1 is a software trigger event. `sw_start_o` is high for exactly the one cycle that follows that write edge.
- R4: A write with bit 0 = 0 clears the software request flag. A `sync_done_i` pulse also clears the flag if it is set and no write happens in that cycle.
- R5: A write of 1 to the software request in the same cycle as `sync_done_i` starts a new synchronization (a new `sw_start_o` pulse), and the flag stays 1.
- R6: The software request flag clears at the first `load_pt_i` pulse after the write in these modes:
  - enhanced=0 with pwmsync=1
  - enhanced=0 with reinit=0
  - enhanced=1 with counter-reset=0

  A `load_pt_i` pulse in the same cycle as the write does not clear it.
- R7: With enhanced=0, pwmsync=0 and reinit=1, or with enhanced=1 and counter-reset=1, a software trigger still pulses `sw_start_o`, but the flag reads 0 after the write edge. The mode bits taken are those being written.
- R8: Take the edge at which a hardware input is first sampled high as edge k. If that input is enabled, `hw_start_o[i]` is high from edge k+2 to edge k+3. A level held high gives exactly one event, and a falling edge gives none.
- R9: A rising edge on a hardware input whose enable flag is 0 is ignored: there is no start pulse and no flag changes.
- R10: With hold mode = 0, a hardware enable flag clears at the same edge at which its start pulse rises.
- R11: With hold mode = 1, a hardware enable flag stays 1 through any number of events until software writes 0 to it.
- R12: When a software write of 1 and an automatic clear hit the same flag in the same cycle, the write wins and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 9 | Configuration write data (layout in R2) |
| load_pt_i | input | 1 | Selected loading-point pulse |
| sync_done_i | input | 1 | Synchronization-complete pulse |
| hw_trig_i | input | 3 | Asynchronous hardware trigger inputs |
| sw_req_o | output | 1 | Software request flag |
| hw_en_o | output | 3 | Hardware trigger enable flags |
| sw_start_o | output | 1 | Software synchronization start pulse |
| hw_start_o | output | 3 | Hardware synchronization start pulses, one per input |

## Verification
Some rules can be checked on every cycle, and assertions check them:
- how each flag moves after a write of 0 or 1
- the completion clear and the loading-point clear of the software flag
- hold-mode retention and the automatic clear of the enable flags
- that a hardware start never rises while its input is disabled

Other behaviour needs a scenario, and only the bench shows it:
- the exact two-edge latency through the synchronizer
- that a level held high gives only one event
- that all inputs behave the same
- that the mode bits written together with the trigger select the immediate clear

The bench also places a write and an automatic clear in the same cycle, and checks which one wins.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;

  // Field order matches cfg_wdata_i[MODE_LSB +: MODE_W], msb first.
  typedef struct packed {
    logic swrst_sel;
    logic reinit_sel;
    logic pwmsync_sel;
    logic enh_mode;
    logic hold_mode;
  } sync_mode_t;

  localparam int unsigned MODE_W = $bits(sync_mode_t);

  // 1: software request clears in the event cycle; 0: at next loading point
  function automatic logic sw_clr_at_event(sync_mode_t m);
    if (m.enh_mode) return m.swrst_sel;
    return !m.pwmsync_sel && m.reinit_sel;
  endfunction

endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= 1'b0;
    else         chain_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= 1'b0;
      else         chain_q[s] <= chain_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] && !prev_q;

  // R8
  rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/hw_trig_flag.sv
module hw_trig_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic wbit_i,
  input  logic hold_i,
  input  logic rise_i,
  output logic en_o,
  output logic start_o
);

  logic en_q, start_q, ev;

  assign ev = rise_i && en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= ev;
      if (we_i)              en_q <= wbit_i;   // write wins
      else if (ev && !hold_i) en_q <= 1'b0;
    end
  end

  assign en_o    = en_q;
  assign start_o = start_q;

  // R9
  start_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(en_o));
  // R10
  auto_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !hold_i && en_o && rise_i) |=> (!en_o && start_o));
  // R11
  hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && hold_i && en_o) |=> en_o);
  // R12
  wr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wbit_i) |=> en_o);

endmodule

// File: rtl/sw_sync_flag.sv
module sw_sync_flag
  import pwm_sync_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic       wbit_i,
  input  sync_mode_t mode_i,
  input  logic       load_pt_i,
  input  logic       done_i,
  output logic       req_o,
  output logic       start_o
);

  logic req_q, start_q, ev, imm;

  assign ev  = we_i && wbit_i;
  assign imm = sw_clr_at_event(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= ev;
      if (ev)                                    req_q <= !imm;
      else if (we_i)                             req_q <= 1'b0;
      else if (done_i || (load_pt_i && !imm))    req_q <= 1'b0;
    end
  end

  assign req_o   = req_q;
  assign start_o = start_q;

  // R4
  wr0_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wbit_i) |=> !req_o);
  // R4
  done_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && req_o && done_i) |=> !req_o);
  // R5
  wr1_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wbit_i && !imm) |=> (req_o && start_o));
  // R7
  imm_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wbit_i && imm) |=> (!req_o && start_o));
  // R6
  load_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && req_o && load_pt_i) |=> !req_o);
  // R6
  req_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && req_o && !done_i && !load_pt_i) |=> req_o);

endmodule

// File: rtl/pwm_sync_trig_ctrl.sv
module pwm_sync_trig_ctrl
  import pwm_sync_pkg::*;
#(
  parameter int unsigned NUM_TRIG    = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned EN_LSB     = 1,
  localparam int unsigned MODE_LSB   = EN_LSB + NUM_TRIG,
  localparam int unsigned CFG_W      = MODE_LSB + MODE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [CFG_W-1:0]    cfg_wdata_i,
  input  logic                load_pt_i,
  input  logic                sync_done_i,
  input  logic [NUM_TRIG-1:0] hw_trig_i,
  output logic                sw_req_o,
  output logic [NUM_TRIG-1:0] hw_en_o,
  output logic                sw_start_o,
  output logic [NUM_TRIG-1:0] hw_start_o
);

  sync_mode_t mode_q, mode_wr, mode_eff;

  assign mode_wr  = sync_mode_t'(cfg_wdata_i[MODE_LSB +: MODE_W]);
  assign mode_eff = cfg_we_i ? mode_wr : mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mode_q <= '0;
    else if (cfg_we_i) mode_q <= mode_wr;
  end

  sw_sync_flag i_sw_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .wbit_i    (cfg_wdata_i[0]),
    .mode_i    (mode_eff),
    .load_pt_i (load_pt_i),
    .done_i    (sync_done_i),
    .req_o     (sw_req_o),
    .start_o   (sw_start_o)
  );

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_trig
    logic rise;

    trig_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (hw_trig_i[i]),
      .rise_o  (rise)
    );

    hw_trig_flag i_flag (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (cfg_we_i),
      .wbit_i  (cfg_wdata_i[EN_LSB+i]),
      .hold_i  (mode_eff.hold_mode),
      .rise_i  (rise),
      .en_o    (hw_en_o[i]),
      .start_o (hw_start_o[i])
    );
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rst_ni) |-> (!sw_req_o && hw_en_o == '0 && !sw_start_o && hw_start_o == '0));

endmodule

// File: tb/test_pwm_sync_trig_ctrl.sv
module test_pwm_sync_trig_ctrl;

  localparam int NT = 3;
  localparam int CW = NT + 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [CW-1:0] cfg_wdata = '0;
  logic          load_pt = 1'b0;
  logic          sync_done = 1'b0;
  logic [NT-1:0] hw_trig = '0;
  logic          sw_req, sw_start;
  logic [NT-1:0] hw_en, hw_start;

  int checks = 0;
  int errors = 0;
  int exp_q[$];   // 0 = software, 1+i = hardware input i

  always #4 clk = ~clk;

  pwm_sync_trig_ctrl i_pwm_sync_trig_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .load_pt_i(load_pt), .sync_done_i(sync_done), .hw_trig_i(hw_trig),
    .sw_req_o(sw_req), .hw_en_o(hw_en), .sw_start_o(sw_start), .hw_start_o(hw_start)
  );

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pop expected start pulses in order
  task automatic mon_item(input int code);
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R3 unexpected start code actual=%0d expected=none", code);
    end else begin
      int e = exp_q.pop_front();
      if (e != code) begin
        errors++;
        $display("FAIL R8 start order actual=%0d expected=%0d", code, e);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (sw_start) mon_item(0);
      for (int i = 0; i < NT; i++) if (hw_start[i]) mon_item(1 + i);
    end
  end

  task automatic wr(input logic [CW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    if (d[0]) exp_q.push_back(0);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_load;
    @(negedge clk); load_pt = 1'b1;
    @(negedge clk); load_pt = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    // R1 reset state
    chk(sw_req, 0, "R1"); chk(hw_en, 0, "R1");
    chk(sw_start, 0, "R1"); chk(hw_start, 0, "R1");
    rst_n = 1'b1;
    idle(2);

    // R3/R6 loading-point mode (all mode bits 0)
    wr(9'h001);
    chk(sw_req, 1, "R3"); chk(sw_start, 1, "R3");
    idle(1);
    chk(sw_start, 0, "R3");
    pulse_load();
    chk(sw_req, 0, "R6");

    // R6 load in the write cycle does not clear
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = 9'h001; load_pt = 1'b1; exp_q.push_back(0);
    @(negedge clk); cfg_we = 1'b0; load_pt = 1'b0;
    chk(sw_req, 1, "R6");
    idle(2);
    chk(sw_req, 1, "R6");
    pulse_load();
    chk(sw_req, 0, "R6");

    // R4 completion and write 0
    wr(9'h001);
    @(negedge clk); sync_done = 1'b1;
    @(negedge clk); sync_done = 1'b0;
    chk(sw_req, 0, "R4");
    wr(9'h001);
    wr(9'h000);
    chk(sw_req, 0, "R4");

    // R5 new trigger together with completion
    wr(9'h001);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = 9'h001; sync_done = 1'b1; exp_q.push_back(0);
    @(negedge clk); cfg_we = 1'b0; sync_done = 1'b0;
    chk(sw_req, 1, "R5"); chk(sw_start, 1, "R5");
    wr(9'h000);

    // R7 immediate-clear modes
    wr(9'h081);                     // enh=0 pwmsync=0 reinit=1
    chk(sw_req, 0, "R7"); chk(sw_start, 1, "R7");
    wr(9'h121);                     // enh=1 swrst=1
    chk(sw_req, 0, "R7"); chk(sw_start, 1, "R7");

    // R6 other loading-point modes
    wr(9'h021);                     // enh=1 swrst=0
    chk(sw_req, 1, "R6");
    pulse_load();
    chk(sw_req, 0, "R6");
    wr(9'h0C1);                     // enh=0 pwmsync=1 reinit=1
    chk(sw_req, 1, "R6");
    pulse_load();
    chk(sw_req, 0, "R6");

    // R2 field layout: enables on bits 1..3
    wr(9'h00E);
    chk(hw_en, 7, "R2"); chk(sw_req, 0, "R2");
    wr(9'h002);                     // en0 only, hold=0
    chk(hw_en, 1, "R2");

    // R8/R10 latency and auto clear
    @(negedge clk); hw_trig[0] = 1'b1; exp_q.push_back(1);   // edge k next
    @(negedge clk); chk(hw_start, 0, "R8");
    @(negedge clk); chk(hw_start, 0, "R8");
    @(negedge clk); chk(hw_start, 1, "R8"); chk(hw_en, 0, "R10");
    @(negedge clk); chk(hw_start, 0, "R8");
    idle(4);                        // level held high: no more events
    hw_trig[0] = 1'b0;
    idle(4);                        // falling edge: none

    // R9 disabled input ignored
    @(negedge clk); hw_trig[1] = 1'b1;
    idle(5);
    chk(hw_start, 0, "R9"); chk(hw_en, 0, "R9");
    hw_trig[1] = 1'b0;
    idle(4);

    // R8 input 2 same latency
    wr(9'h008);
    @(negedge clk); hw_trig[2] = 1'b1; exp_q.push_back(3);
    idle(2);
    chk(hw_start, 0, "R8");
    @(negedge clk); chk(hw_start, 4, "R8"); chk(hw_en, 0, "R10");
    hw_trig[2] = 1'b0;
    idle(4);

    // R11 hold mode keeps enables through events
    wr(9'h01C);                     // en1, en2, hold
    for (int n = 0; n < 2; n++) begin
      @(negedge clk); hw_trig[1] = 1'b1; exp_q.push_back(2);
      idle(4);
      hw_trig[1] = 1'b0;
      idle(3);
      chk(hw_en, 6, "R11");
    end
    wr(9'h010);
    chk(hw_en, 0, "R11");

    // R12 write of 1 in the cycle of an automatic clear
    wr(9'h002);
    @(negedge clk); hw_trig[0] = 1'b1; exp_q.push_back(1);
    @(negedge clk);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = 9'h002;
    @(negedge clk); cfg_we = 1'b0;
    chk(hw_start, 1, "R12"); chk(hw_en, 1, "R12");
    hw_trig[0] = 1'b0;
    idle(4);

    chk(exp_q.size(), 0, "R3");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule